// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single line. A one-entry holding buffer sits in front of the shift register. Software, or an upstream engine, can therefore queue the next character while the current one is still going out, and consecutive frames leave with no idle gap between them. Character length is 5, 6, 7, 8 or 9 bits. Parity may be off, even or odd. One or two stop bits may be selected. Bit timing comes from an external `tick` strobe that pulses once per bit period; baud generation is not part of this block.

Characters enter on a valid/ready port. `s_ready` doubles as the buffer-empty flag. A beat is taken on a rising clock edge when `s_valid` and `s_ready` are both high. A beat offered while `s_ready` is low is neither taken nor remembered, so the offer is simply lost unless the source keeps `s_valid` high until it sees `s_ready`. A sticky completion flag reports that the line has drained. The enable input can be dropped at any time: the transmitter keeps control of the line until everything already queued has been sent.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset, `txd` is 1, `s_ready` is 1, `tx_done` is 0 and `line_drive` is 0.
- R2: A beat is taken only on an edge where `s_ready` is 1, and `s_ready` is 0 in the next cycle. A beat offered while `s_ready` is 0 is discarded and is never transmitted.
- R3: A buffered character moves into the shift register on a clock edge where `tick` is 1 and the transmitter owns the line and the shift register is idle or is ending its last stop bit. `s_ready` returns to 1 at that same edge, and the start bit appears on `txd` at that same edge.
- R4: A frame is a start bit (0), then the data bits least significant first, then the optional parity bit, then the stop bits (1). `txd` changes only on edges where `tick` is 1, so every bit lasts exactly one tick period. `txd` rests at 1 when nothing is being sent.
- R5: When `two_stop` is 0, the frame has one stop bit. When it is 1, the frame has two stop bits.
- R6: `par_mode` 2'b10 appends even parity. 2'b11 appends odd parity. 2'b00 and 2'b01 append no parity bit. Parity is taken over the data bits that are actually sent.
- R7: `char_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and 7 selects 9. The codes 4 to 6 behave as 8 bits. Beat bits above the selected length are ignored.
- R8: In 9-bit mode, the ninth data bit is `s_hi` as sampled together with the beat.
- R9: `tx_done` rises on the tick edge that ends a frame's last stop bit, but only when no character waits in the buffer. When a buffered character follows at that edge, `tx_done` stays 0.
- R10: `tx_done` stays 1 until a cycle with `done_clr` or `done_ack` high clears it.
- R11: Once `enable` is 0, queued data is still sent completely. `line_drive` then falls, and data written while the line is released waits in the buffer until `enable` returns to 1.
- R12: When a character waits in the buffer, its start bit follows the previous frame's last stop bit with no idle period in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Transmitter enable; a fall takes effect after queued data has been sent |
| char_len | input | 3 | Character length code |
| par_mode | input | 2 | Parity mode: bit 1 enables parity, bit 0 selects odd |
| two_stop | input | 1 | 1 selects two stop bits |
| tick | input | 1 | One-cycle strobe, one per bit period |
| s_valid | input | 1 | Character beat valid |
| s_ready | output | 1 | Holding buffer empty; beat accepted when high |
| s_data | input | DATA_W-1 | Low data bits of the beat |
| s_hi | input | 1 | Ninth data bit of the beat |
| done_clr | input | 1 | Write-one clear of `tx_done` |
| done_ack | input | 1 | Service acknowledge that also clears `tx_done` |
| txd | output | 1 | Serial line |
| line_drive | output | 1 | High while the transmitter owns the line |
| tx_done | output | 1 | Sticky flag: line drained with the buffer empty |

## Verification
The bench builds the block with its default `DATA_W` of 9, so the longest frame format is available: 9 data bits, parity and two stop bits, 13 bit periods in all. It pulses `tick` every 8 clocks. At that rate each bit is wide enough to be sampled at its middle. The same rate brings back-to-back frames, a write rejected while the buffer is full, and a disable that lands while two characters are still queued within a short run. Frames are decoded from `txd` alone and compared with data, parity and stop bits worked out from the configuration.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_RSV  = 2'b01,
    PM_EVEN = 2'b10,
    PM_ODD  = 2'b11
  } parity_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } fmt_t;

  // Character length code to number of data bits; unused codes act as 8.
  function automatic logic [3:0] width_of(input logic [2:0] code);
    case (code)
      3'd0:    width_of = 4'd5;
      3'd1:    width_of = 4'd6;
      3'd2:    width_of = 4'd7;
      3'd3:    width_of = 4'd8;
      3'd7:    width_of = 4'd9;
      default: width_of = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/utx_holdbuf.sv
module utx_holdbuf #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_word,
  output logic          s_ready,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (s_valid && !full) begin
      full <= 1'b1;
      word <= s_word;
    end
  end

  assign s_ready = !full;

endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
#(
  parameter int DW = 9,
  parameter int FW = DW + 4,
  parameter int CW = $clog2(FW + 1)
) (
  input  fmt_t          fmt,
  input  logic [DW-1:0] word,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] len
);

  always_comb begin
    int            n;
    logic [DW-1:0] kept;
    logic          pbit;
    n = (int'(fmt.nbits) > DW) ? DW : int'(fmt.nbits);
    kept = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < n) kept[i] = word[i];
    end
    pbit = (^kept) ^ fmt.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < n) frame[i+1] = kept[i];
    end
    for (int j = 0; j < FW; j++) begin
      if (fmt.par_en && (j == n + 1)) frame[j] = pbit;
    end
    len = CW'(2 + n + (fmt.par_en ? 1 : 0) + (fmt.stop2 ? 1 : 0));
  end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int FW = 13,
  parameter int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] len,
  output logic          bit_out,
  output logic          busy,
  output logic          last
);

  logic [FW-1:0] sr;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sr   <= frame;
      left <= len;
      busy <= 1'b1;
    end else if (tick && busy) begin
      sr   <= {1'b1, sr[FW-1:1]};
      left <= left - CW'(1);
      if (left == CW'(1)) busy <= 1'b0;
    end
  end

  assign last    = busy && (left == CW'(1));
  assign bit_out = busy ? sr[0] : 1'b1;

endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic busy,
  input  logic last,
  input  logic hold_full,
  input  logic done_clr,
  input  logic done_ack,
  output logic load,
  output logic own_line,
  output logic tx_done
);

  logic frame_end;

  assign load      = tick && hold_full && own_line && (!busy || last);
  assign frame_end = tick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_line <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      own_line <= enable || (own_line && (busy || hold_full));
      if (frame_end && !hold_full) tx_done <= 1'b1;
      else if (done_clr || done_ack) tx_done <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
  import utx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic              tick,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-2:0] s_data,
  input  logic              s_hi,
  input  logic              done_clr,
  input  logic              done_ack,
  output logic              txd,
  output logic              line_drive,
  output logic              tx_done
);

  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(FW + 1);

  fmt_t              fmt;
  logic              hold_full;
  logic [DATA_W-1:0] hold_word;
  logic [FW-1:0]     frame;
  logic [CW-1:0]     len;
  logic              load, busy, last, bit_out, own_line;

  always_comb begin
    fmt.nbits   = width_of(char_len);
    fmt.par_en  = par_mode[1];
    fmt.par_odd = (par_mode == PM_ODD);
    fmt.stop2   = two_stop;
  end

  utx_holdbuf #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_word({s_hi, s_data}),
    .s_ready(s_ready), .take(load), .full(hold_full), .word(hold_word)
  );

  utx_framer #(.DW(DATA_W), .FW(FW), .CW(CW)) u_frame (
    .fmt(fmt), .word(hold_word), .frame(frame), .len(len)
  );

  utx_shifter #(.FW(FW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .frame(frame),
    .len(len), .bit_out(bit_out), .busy(busy), .last(last)
  );

  utx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .busy(busy),
    .last(last), .hold_full(hold_full), .done_clr(done_clr),
    .done_ack(done_ack), .load(load), .own_line(own_line), .tx_done(tx_done)
  );

  assign txd        = own_line ? bit_out : 1'b1;
  assign line_drive = own_line;

endmodule

// File: rtl/uart_tx_buffered_chk.sv
module uart_tx_buffered_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tick,
  input logic s_valid,
  input logic s_ready,
  input logic done_clr,
  input logic done_ack,
  input logic txd,
  input logic line_drive,
  input logic tx_done
);

  // R2
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R3
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(tick));

  // R4
  line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));

  // R11
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_drive |-> txd);

  // R11
  stay_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !line_drive) |=> !line_drive);

  // R9
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_done && !tick) |=> !tx_done);

  // R9
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(s_ready));

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tick && (done_clr || done_ack)) |=> !tx_done);

endmodule

bind uart_tx_buffered uart_tx_buffered_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
  .s_valid(s_valid), .s_ready(s_ready), .done_clr(done_clr),
  .done_ack(done_ack), .txd(txd), .line_drive(line_drive), .tx_done(tx_done)
);

// File: tb/uart_tx_buffered_test.sv
module uart_tx_buffered_test;

  localparam int DIV = 8;
  localparam int DW  = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [2:0] char_len = 3'd3;
  logic [1:0] par_mode = 2'b00;
  logic two_stop = 1'b0;
  logic tick = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [DW-2:0] s_data = '0;
  logic s_hi = 1'b0;
  logic done_clr = 1'b0;
  logic done_ack = 1'b0;
  logic txd, line_drive, tx_done;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  uart_tx_buffered #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .char_len(char_len),
    .par_mode(par_mode), .two_stop(two_stop), .tick(tick),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_hi(s_hi),
    .done_clr(done_clr), .done_ack(done_ack), .txd(txd),
    .line_drive(line_drive), .tx_done(tx_done)
  );

  initial begin
    forever begin
      repeat (DIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_up();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic set_fmt(input logic [2:0] cl, input logic [1:0] pm, input logic ts);
    @(negedge clk);
    char_len = cl;
    par_mode = pm;
    two_stop = ts;
  endtask

  task automatic push(input logic [DW-1:0] w, output bit acc);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = w[DW-2:0];
    s_hi    = w[DW-1];
    acc     = s_ready;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic pulse_clear(input bit use_ack);
    @(negedge clk);
    if (use_ack) done_ack = 1'b1; else done_clr = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
    done_clr = 1'b0;
  endtask

  task automatic wait_start(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (txd !== 1'b0 && gap < 4000);
    chk(gap < 4000, "R4", "start bit seen", gap, 0);
  endtask

  // Called at the first negedge of a start bit; returns in the middle of the last stop bit.
  task automatic rx_body(input int n, input bit par_on, input bit odd, input int stops,
                         input logic [DW-1:0] w, input string req);
    logic [DW-1:0] m, got;
    logic p;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = w[i];
    got = '0;
    repeat (DIV / 2) @(negedge clk);
    chk(txd === 1'b0, "R4", "start bit level", int'(txd), 0);
    for (int i = 0; i < n; i++) begin
      repeat (DIV) @(negedge clk);
      got[i] = txd;
    end
    chk(got === m, req, "data bits", int'(got), int'(m));
    if (par_on) begin
      p = (^m) ^ odd;
      repeat (DIV) @(negedge clk);
      chk(txd === p, "R6", "parity bit", int'(txd), int'(p));
    end
    for (int s = 0; s < stops; s++) begin
      repeat (DIV) @(negedge clk);
      chk(txd === 1'b1, "R5", "stop bit", int'(txd), 1);
    end
  endtask

  task automatic send_one(input logic [DW-1:0] w, input int n, input bit par_on,
                          input bit odd, input int stops, input string req);
    bit acc;
    int gap;
    push(w, acc);
    chk(acc, "R2", "beat taken when empty", int'(acc), 1);
    wait_start(gap);
    rx_body(n, par_on, odd, stops, w, req);
    repeat (DIV) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && s_ready === 1'b1, "R1", "line/ready in reset",
        int'({txd, s_ready}), 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(s_ready === 1'b1, "R1", "s_ready after reset", int'(s_ready), 1);
    chk(tx_done === 1'b0, "R1", "tx_done after reset", int'(tx_done), 0);
    chk(line_drive === 1'b0, "R1", "line_drive after reset", int'(line_drive), 0);
  endtask

  task automatic t_basic8();
    enable = 1'b1;
    set_fmt(3'd3, 2'b00, 1'b0);
    send_one(9'h0A5, 8, 1'b0, 1'b0, 1, "R4");
    chk(tx_done === 1'b1, "R9", "done after single frame", int'(tx_done), 1);
    chk(line_drive === 1'b1, "R11", "line owned while enabled", int'(line_drive), 1);
    send_one(9'h03C, 8, 1'b0, 1'b0, 1, "R4");
  endtask

  task automatic t_parity_len();
    set_fmt(3'd0, 2'b10, 1'b0);
    send_one(9'h1FF, 5, 1'b1, 1'b0, 1, "R7");
    set_fmt(3'd2, 2'b11, 1'b0);
    send_one(9'h0F3, 7, 1'b1, 1'b1, 1, "R7");
    set_fmt(3'd1, 2'b01, 1'b0);
    send_one(9'h02D, 6, 1'b0, 1'b0, 1, "R6");
    set_fmt(3'd5, 2'b10, 1'b1);
    send_one(9'h181, 8, 1'b1, 1'b0, 2, "R7");
  endtask

  task automatic t_nine();
    set_fmt(3'd7, 2'b11, 1'b1);
    send_one(9'h13C, 9, 1'b1, 1'b1, 2, "R8");
    send_one(9'h03C, 9, 1'b1, 1'b1, 2, "R8");
  endtask

  task automatic t_full_drop();
    set_fmt(3'd3, 2'b00, 1'b0);
    pulse_clear(1'b0);
    chk(tx_done === 1'b0, "R10", "cleared by done_clr", int'(tx_done), 0);
    fork
      begin
        int gap;
        bit stay;
        wait_start(gap);
        rx_body(8, 1'b0, 1'b0, 1, 9'h055, "R12");
        wait_start(gap);
        chk(gap == DIV / 2, "R12", "gap between frames", gap, DIV / 2);
        chk(tx_done === 1'b0, "R9", "no done while next loads", int'(tx_done), 0);
        rx_body(8, 1'b0, 1'b0, 1, 9'h0C3, "R12");
        repeat (DIV) @(negedge clk);
        chk(tx_done === 1'b1, "R9", "done after drain", int'(tx_done), 1);
        stay = 1'b1;
        for (int k = 0; k < 14 * DIV; k++) begin
          @(negedge clk);
          if (txd !== 1'b1) stay = 1'b0;
        end
        chk(stay, "R2", "dropped beat never sent", int'(stay), 1);
      end
      begin
        bit acc;
        push(9'h055, acc);
        chk(acc, "R2", "first beat taken", int'(acc), 1);
        chk(s_ready === 1'b0, "R2", "ready low after take", int'(s_ready), 0);
        do @(negedge clk); while (txd !== 1'b0);
        chk(s_ready === 1'b1, "R3", "ready with start bit", int'(s_ready), 1);
        push(9'h0C3, acc);
        chk(acc, "R2", "second beat taken", int'(acc), 1);
        push(9'h0FF, acc);
        chk(!acc, "R2", "beat refused while full", int'(acc), 0);
      end
    join
  endtask

  task automatic t_clear();
    pulse_clear(1'b1);
    chk(tx_done === 1'b0, "R10", "cleared by done_ack", int'(tx_done), 0);
    send_one(9'h011, 8, 1'b0, 1'b0, 1, "R4");
    chk(tx_done === 1'b1, "R9", "done set again", int'(tx_done), 1);
    repeat (3 * DIV) @(negedge clk);
    chk(tx_done === 1'b1, "R10", "done holds until cleared", int'(tx_done), 1);
    pulse_clear(1'b0);
    chk(tx_done === 1'b0, "R10", "done_clr clears", int'(tx_done), 0);
  endtask

  task automatic t_defer();
    bit acc, stay;
    int gap;
    set_fmt(3'd3, 2'b10, 1'b0);
    fork
      begin
        int g;
        wait_start(g);
        rx_body(8, 1'b1, 1'b0, 1, 9'h0A0, "R11");
        wait_start(g);
        rx_body(8, 1'b1, 1'b0, 1, 9'h00F, "R11");
        repeat (DIV) @(negedge clk);
        chk(line_drive === 1'b0, "R11", "line released after drain", int'(line_drive), 0);
      end
      begin
        bit a;
        push(9'h0A0, a);
        do @(negedge clk); while (txd !== 1'b0);
        push(9'h00F, a);
        chk(a, "R11", "second beat queued", int'(a), 1);
        enable = 1'b0;
      end
    join
    push(9'h0E7, acc);
    chk(acc, "R11", "beat taken while released", int'(acc), 1);
    stay = 1'b1;
    for (int k = 0; k < 20 * DIV; k++) begin
      @(negedge clk);
      if (txd !== 1'b1 || s_ready !== 1'b0) stay = 1'b0;
    end
    chk(stay, "R11", "data held while disabled", int'(stay), 1);
    enable = 1'b1;
    wait_start(gap);
    rx_body(8, 1'b1, 1'b0, 1, 9'h0E7, "R11");
    repeat (DIV) @(negedge clk);
    chk(s_ready === 1'b1, "R3", "buffer empty after send", int'(s_ready), 1);
  endtask

  initial begin
    t_reset();
    t_basic8();
    t_parity_len();
    t_nine();
    t_full_drop();
    t_clear();
    t_defer();
    finish_up();
  end

endmodule